// File: doc/BRIEF.md
# Per-Task Result Write Redirection Unit

This unit sits between the execute stage of a small multi-task core and the write port of its local register file. Every hardware task owns a private redirection address register and a three-bit mode. While a task's mode is active, the destination address of that task's result write is replaced by the redirection address, which may then stay put, step up by one or step down by one after use. Redirection lasts either for a single result write or until the task cancels it.

Commands arrive on a plain control bus (valid, task id, load flag, mode code, operand). A command with the load flag set copies the operand into the task's redirection register and sets the mode in the same cycle. Without the load flag it changes only the mode. Result writes arrive as a valid/ready stream (`wr_valid`/`wr_ready`) carrying task id and destination address. They leave as a stream (`rf_valid`/`rf_ready`) carrying the final address. The path is combinational: `rf_valid` follows `wr_valid` and `wr_ready` follows `rf_ready`. A write is consumed only in a cycle where `wr_valid` and `rf_ready` are both high. While the sink holds `rf_ready` low, the presented address is held and no state moves. The address is always a local register-file index, never a shared memory address.

Top module: `redir_unit`

## Requirements
- R1: Commands and consumed writes of one task never change the mode or redirection register of any other task.
- R2: For a task in normal mode, `rf_addr` equals `wr_addr` and `rf_redirected` is 0. In every mode, `rf_valid` equals `wr_valid` and `wr_ready` equals `rf_ready`.
- R3: The mode code is {persist, step[1:0]}. For step, 01 keeps the address, 10 post-increments after each consumed redirected write, and 11 post-decrements. Stepping wraps modulo 512, so 511+1 gives 0 and 0-1 gives 511.
- R4: One-shot modes (persist=0) redirect only the next consumed write of the task, and the task then returns to normal mode.
- R5: Persistent modes (persist=1) redirect every consumed write of the task until cancelled. With post-increment, back-to-back writes go to consecutive addresses, one per cycle.
- R6: A command with `cmd_load`=1 loads `cmd_operand` into the task's redirection register. With `cmd_load`=0 the register keeps its value.
- R7: A step field of 00 is a cancel command, whatever the persist bit. It returns the task to normal mode (reported as 000), and its loading form still writes the operand.
- R8: A write that is not consumed (`wr_valid` low, or `rf_ready` low) neither uses up a one-shot redirection nor steps the address.
- R9: When a command and a consumed write of the same task share a cycle, the write is redirected according to the old state and the command's mode applies from the next cycle. The register then takes the loaded operand if `cmd_load`=1, and otherwise takes the stepped address.
- R10: After reset every task is in mode 000 with its redirection register at 0. `task_mode` reports the mode of task i on bits [3i+2:3i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_task | input | 2 | Task addressed by the command |
| cmd_load | input | 1 | Load operand into the redirection register |
| cmd_mode | input | 3 | Mode code {persist, step[1:0]} |
| cmd_operand | input | 9 | Address loaded when cmd_load is set |
| wr_valid | input | 1 | Result write request valid |
| wr_ready | output | 1 | Result write accepted (follows rf_ready) |
| wr_task | input | 2 | Task issuing the write |
| wr_addr | input | 9 | Destination address from the instruction |
| rf_valid | output | 1 | Write toward the register file valid |
| rf_ready | input | 1 | Register file can take the write |
| rf_addr | output | 9 | Final write address |
| rf_redirected | output | 1 | Address was replaced by redirection |
| task_mode | output | 12 | Current mode of every task, 3 bits each |

## Verification
On every cycle, the assertions check that each task's state moves only when that task is addressed (R1), and that normal-mode writes pass through unchanged (R2). They also check the one-step movement of the redirection register for the increment and decrement modes and that a one-shot mode clears after one consumed write. They check that persistent modes survive use, that cancel lands in mode 000, and that a non-loading command leaves the register alone. Only the bench's scenarios show the results that span many cycles. These are the wrap at both ends of the address range, an unbroken run of consecutive addresses under persistent increment, a stalled write that stays pending, the ordering when a command and a write collide, and the cleared register after reset.

// File: rtl/redir_pkg.sv
package redir_pkg;

  typedef enum logic [1:0] {
    STEP_OFF  = 2'b00,
    STEP_HOLD = 2'b01,
    STEP_UP   = 2'b10,
    STEP_DOWN = 2'b11
  } step_e;

  typedef struct packed {
    logic  persist;
    step_e step;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

endpackage

// File: rtl/redir_stepper.sv
module redir_stepper
  import redir_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic [AW-1:0] addr_i,
  input  step_e         step_i,
  output logic [AW-1:0] addr_o
);

  always_comb begin
    unique case (step_i)
      STEP_UP:   addr_o = addr_i + AW'(1);
      STEP_DOWN: addr_o = addr_i - AW'(1);
      default:   addr_o = addr_i;
    endcase
  end

endmodule

// File: rtl/redir_slot.sv
module redir_slot
  import redir_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_hit,
  input  logic          cmd_load,
  input  mode_t         cmd_mode,
  input  logic [AW-1:0] cmd_operand,
  input  logic          use_hit,
  output mode_t         mode_q,
  output logic [AW-1:0] rdr_q
);

  logic          active;
  logic [AW-1:0] stepped;
  mode_t         mode_cmd_n;
  mode_t         mode_d;
  logic [AW-1:0] rdr_d;

  assign active = (mode_q.step != STEP_OFF);

  redir_stepper #(.AW(AW)) u_step (
    .addr_i (rdr_q),
    .step_i (mode_q.step),
    .addr_o (stepped)
  );

  // a cancel code is stored as all zeros, persist bit dropped
  always_comb begin
    mode_cmd_n = cmd_mode;
    if (cmd_mode.step == STEP_OFF) mode_cmd_n = '0;
  end

  always_comb begin
    mode_d = mode_q;
    rdr_d  = rdr_q;
    if (use_hit && active) begin
      rdr_d = stepped;
      if (!mode_q.persist) mode_d = '0;
    end
    if (cmd_hit) begin
      mode_d = mode_cmd_n;
      if (cmd_load) rdr_d = cmd_operand;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      rdr_q  <= '0;
    end else begin
      mode_q <= mode_d;
      rdr_q  <= rdr_d;
    end
  end

  p_quiet_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_hit && !use_hit) |=> ($stable(mode_q) && $stable(rdr_q)));

  p_step_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (use_hit && mode_q.step == STEP_UP && !(cmd_hit && cmd_load))
      |=> (rdr_q == $past(rdr_q) + AW'(1)));

  p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (use_hit && mode_q.step == STEP_DOWN && !(cmd_hit && cmd_load))
      |=> (rdr_q == $past(rdr_q) - AW'(1)));

  p_oneshot_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (use_hit && active && !mode_q.persist && !cmd_hit) |=> (mode_q == '0));

  p_persist_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (use_hit && active && mode_q.persist && !cmd_hit) |=> $stable(mode_q));

  p_noload_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && !cmd_load && !use_hit) |=> $stable(rdr_q));

  p_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && cmd_mode.step == STEP_OFF) |=> (mode_q == '0));

endmodule

// File: rtl/redir_unit.sv
module redir_unit
  import redir_pkg::*;
#(
  parameter int AW    = 9,
  parameter int TASKS = 4,
  localparam int TW   = (TASKS > 1) ? $clog2(TASKS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [TW-1:0]         cmd_task,
  input  logic                  cmd_load,
  input  logic [MODE_W-1:0]     cmd_mode,
  input  logic [AW-1:0]         cmd_operand,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  input  logic [TW-1:0]         wr_task,
  input  logic [AW-1:0]         wr_addr,
  output logic                  rf_valid,
  input  logic                  rf_ready,
  output logic [AW-1:0]         rf_addr,
  output logic                  rf_redirected,
  output logic [TASKS*MODE_W-1:0] task_mode
);

  mode_t         slot_mode [TASKS];
  logic [AW-1:0] slot_rdr  [TASKS];
  logic          fire;
  mode_t         sel_mode;
  logic [AW-1:0] sel_rdr;

  assign fire     = wr_valid && rf_ready;
  assign wr_ready = rf_ready;
  assign rf_valid = wr_valid;

  for (genvar i = 0; i < TASKS; i++) begin : g_slot
    logic cmd_hit_i;
    logic use_hit_i;
    assign cmd_hit_i = cmd_valid && (cmd_task == TW'(i));
    assign use_hit_i = fire && (wr_task == TW'(i));

    redir_slot #(.AW(AW)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_hit     (cmd_hit_i),
      .cmd_load    (cmd_load),
      .cmd_mode    (mode_t'(cmd_mode)),
      .cmd_operand (cmd_operand),
      .use_hit     (use_hit_i),
      .mode_q      (slot_mode[i]),
      .rdr_q       (slot_rdr[i])
    );

    assign task_mode[i*MODE_W +: MODE_W] = slot_mode[i];
  end

  always_comb begin
    sel_mode = '0;
    sel_rdr  = '0;
    for (int k = 0; k < TASKS; k++) begin
      if (wr_task == TW'(k)) begin
        sel_mode = slot_mode[k];
        sel_rdr  = slot_rdr[k];
      end
    end
  end

  assign rf_redirected = wr_valid && (sel_mode.step != STEP_OFF);
  assign rf_addr       = rf_redirected ? sel_rdr : wr_addr;

  p_pass_through_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_valid && !rf_redirected) |-> (rf_addr == wr_addr));

  p_stall_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && !fire) |=> $stable(task_mode));

endmodule

// File: tb/tb_redir_unit.sv
module tb_redir_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_task = '0;
  logic        cmd_load = 1'b0;
  logic [2:0]  cmd_mode = '0;
  logic [8:0]  cmd_operand = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [1:0]  wr_task = '0;
  logic [8:0]  wr_addr = '0;
  logic        rf_valid;
  logic        rf_ready = 1'b1;
  logic [8:0]  rf_addr;
  logic        rf_redirected;
  logic [11:0] task_mode;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  redir_unit dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_task(cmd_task), .cmd_load(cmd_load),
    .cmd_mode(cmd_mode), .cmd_operand(cmd_operand),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_task(wr_task), .wr_addr(wr_addr),
    .rf_valid(rf_valid), .rf_ready(rf_ready), .rf_addr(rf_addr),
    .rf_redirected(rf_redirected), .task_mode(task_mode)
  );

  // {req4, cv, ct2, cl, cm3, co9, wv, wt2, wa9, rr, ev, ea9, er}
  function automatic logic [43:0] v(int req, bit cv, int ct, bit cl, int cm, int co,
                                    bit wv, int wt, int wa, bit rr,
                                    bit ev, int ea, bit er);
    return {4'(req), cv, 2'(ct), cl, 3'(cm), 9'(co), wv, 2'(wt), 9'(wa), rr,
            ev, 9'(ea), er};
  endfunction

  localparam int NV = 30;
  localparam logic [43:0] VEC [0:NV-1] = '{
    v(2, 0,0,0,0,0,     1,0,5,1,   1,5,0),    // R2 normal pass
    v(9, 1,0,1,1,100,   1,0,7,1,   1,7,0),    // R9 old state used
    v(4, 0,0,0,0,0,     1,0,8,1,   1,100,1),  // R4 one-shot fires
    v(4, 0,0,0,0,0,     1,0,9,1,   1,9,0),    // R4 back to normal
    v(1, 1,1,1,6,510,   1,0,10,1,  1,10,0),   // R1 other task untouched
    v(3, 0,0,0,0,0,     1,1,3,1,   1,510,1),  // R3 inc
    v(3, 0,0,0,0,0,     1,1,3,1,   1,511,1),
    v(3, 0,0,0,0,0,     1,1,3,1,   1,0,1),    // R3 wrap up
    v(8, 0,0,0,0,0,     1,1,3,0,   1,1,1),    // R8 stalled
    v(8, 0,0,0,0,0,     1,1,3,1,   1,1,1),    // R8 still 1
    v(8, 0,0,0,0,0,     0,1,3,1,   0,0,0),    // R8 no write
    v(8, 0,0,0,0,0,     1,1,3,1,   1,2,1),
    v(9, 1,1,0,0,0,     1,1,4,1,   1,3,1),    // R9 cancel with write
    v(7, 0,0,0,0,0,     1,1,4,1,   1,4,0),    // R7 cancelled
    v(6, 1,2,1,7,2,     0,0,0,1,   0,0,0),    // R6 load persist dec
    v(3, 0,0,0,0,0,     1,2,50,1,  1,2,1),    // R3 dec
    v(3, 0,0,0,0,0,     1,2,50,1,  1,1,1),
    v(3, 0,0,0,0,0,     1,2,50,1,  1,0,1),
    v(3, 0,0,0,0,0,     1,2,50,1,  1,511,1),  // R3 wrap down
    v(6, 1,2,0,3,0,     0,0,0,1,   0,0,0),    // R6 non-load one-shot dec
    v(6, 0,0,0,0,0,     1,2,50,1,  1,510,1),  // R6 register kept
    v(4, 0,0,0,0,0,     1,2,50,1,  1,50,0),
    v(7, 1,3,1,0,77,    0,0,0,1,   0,0,0),    // R7 loading cancel
    v(7, 1,3,0,1,0,     1,3,6,1,   1,6,0),
    v(7, 0,0,0,0,0,     1,3,6,1,   1,77,1),   // R7 operand was stored
    v(5, 1,0,0,5,0,     0,0,0,1,   0,0,0),    // R5 persist hold
    v(5, 0,0,0,0,0,     1,0,1,1,   1,100,1),
    v(5, 0,0,0,0,0,     1,0,1,1,   1,100,1),
    v(7, 1,0,0,4,0,     1,0,1,1,   1,100,1),  // R7 code 100 cancels
    v(7, 0,0,0,0,0,     1,0,1,1,   1,1,0)
  };

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(bit cv, int ct, bit cl, int cm, int co,
                       bit wv, int wt, int wa, bit rr);
    cmd_valid = cv; cmd_task = 2'(ct); cmd_load = cl; cmd_mode = 3'(cm);
    cmd_operand = 9'(co); wr_valid = wv; wr_task = 2'(wt); wr_addr = 9'(wa);
    rf_ready = rr;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", int'(task_mode), 0, "mode in reset");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [43:0] e;
      string rq;
      e = VEC[i];
      @(negedge clk);
      drive(e[39], int'(e[38:37]), e[36], int'(e[35:33]), int'(e[32:24]),
            e[23], int'(e[22:21]), int'(e[20:12]), e[11]);
      #5;
      rq = $sformatf("R%0d", int'(e[43:40]));
      check(rq, int'(rf_valid), int'(e[10]), $sformatf("row %0d valid", i));
      check(rq, int'(wr_ready), int'(e[11]), $sformatf("row %0d ready", i));
      if (e[10]) begin
        check(rq, int'(rf_addr), int'(e[9:1]), $sformatf("row %0d addr", i));
        check(rq, int'(rf_redirected), int'(e[0]), $sformatf("row %0d redir", i));
      end
    end

    // R5: persistent increment, 100 results in 100 cycles, task 3 from 500
    @(negedge clk); drive(1,3,1,6,500, 0,0,0,1);
    @(negedge clk); drive(0,0,0,0,0, 1,3,9,1);
    #5;
    check("R10", int'(task_mode[11:9]), 6, "task3 mode field");
    check("R1", int'(task_mode[8:0]), 0, "other tasks normal");
    for (int k = 0; k < 100; k++) begin
      if (k > 0) begin @(negedge clk); #5; end
      check("R5", int'(rf_addr), (500 + k) % 512, $sformatf("burst %0d", k));
    end

    // R9: same-cycle non-load command keeps stepping, load overrides
    @(negedge clk); drive(1,1,1,6,40, 0,0,0,1);
    @(negedge clk); drive(1,1,0,6,0, 1,1,0,1); #5;
    check("R9", int'(rf_addr), 40, "collide nonload");
    @(negedge clk); drive(1,1,1,6,200, 1,1,0,1); #5;
    check("R9", int'(rf_addr), 41, "collide load");
    @(negedge clk); drive(0,0,0,0,0, 1,1,0,1); #5;
    check("R9", int'(rf_addr), 200, "after load");

    // R10: re-reset clears mode and register
    @(negedge clk); drive(0,0,0,0,0, 0,0,0,1);
    rst_n = 1'b0;
    @(negedge clk); #5;
    check("R10", int'(task_mode), 0, "mode after reset");
    rst_n = 1'b1;
    @(negedge clk); drive(1,1,0,1,0, 0,0,0,1);
    @(negedge clk); drive(0,0,0,0,0, 1,1,33,1); #5;
    check("R10", int'(rf_addr), 0, "register cleared");
    check("R10", int'(rf_redirected), 1, "redirected after reset");

    @(negedge clk); drive(0,0,0,0,0, 0,0,0,1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule